// File: doc/BRIEF.md
# Serial Identifier Readout Controller

This block recovers a fixed 57-bit identifier from a bit-serial identifier port and presents it as a parallel word. A single start pulse begins a readout. The controller first asks the port to capture its stored identifier in parallel. It then requests 56 single-bit advances, and samples the serial output once after the capture and once after each advance. The port delivers the most significant bit first. The serial feed bit into the port is held at 0 for the whole readout.

The port must never see an advance strobe rise while the clock is high. For this reason both strobes are launched from falling-edge flops, so they change only in the low phase of the clock and are stable at every rising edge. When the readout ends, the controller pulses a done flag for one cycle. At the same time it sets a level valid flag if the top two captured bits are "1" then "0". The result and the flags stay unchanged until the next accepted start.

The only data leaving the block is one finished word. It is announced by a one-cycle done pulse and held until the next start, so the block needs no back-pressure. The caller takes the word at the done pulse, or any time before it issues a new start. Start and done are plain control pins.

Top module: `serial_id_reader`

## Requirements
- R1: While reset is held and right after it is released, id_load_o, id_shift_o, id_feed_o, done_o and valid_o are 0 and id_value_o is all zeros.
- R2: Each accepted start produces exactly one rising edge of the clock at which id_load_o is sampled high, and that edge is the first rising edge after the accepting edge.
- R3: Each readout produces exactly 56 rising edges at which id_shift_o is high, id_load_o and id_shift_o are never high together, and id_feed_o stays 0.
- R4: id_load_o and id_shift_o change only on the falling clock edge; neither ever rises while the clock is high.
- R5: At the end of a readout, id_value_o[56] holds the first bit sampled (the bit shown right after the load), and id_value_o[0] holds the last bit sampled, so id_value_o equals the stored identifier.
- R6: done_o is high for exactly one cycle, 58 rising edges after the edge that accepted start.
- R7: valid_o rises together with done_o exactly when id_value_o[56] is 1 and id_value_o[55] is 0. It stays at that level until the next accepted start, and it is 0 from the edge that accepts that start.
- R8: A start request seen while a readout is in progress is ignored: no extra load, and done_o still comes at the original time.
- R9: After done_o, id_value_o and valid_o hold their values while no start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on the rising edge and the strobes on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Readout request, accepted only when no readout is running |
| id_load_o | output | 1 | Parallel-capture strobe to the identifier port |
| id_shift_o | output | 1 | One-bit advance strobe to the identifier port |
| id_feed_o | output | 1 | Serial feed bit into the port, always 0 |
| id_sdo_i | input | 1 | Serial output bit of the identifier port |
| id_value_o | output | 57 | Assembled identifier, MSB first as received |
| done_o | output | 1 | One-cycle pulse when a readout finishes |
| valid_o | output | 1 | Level flag: the captured prefix bits read "10" |

## Verification
When start is sampled at rising edge P, valid_o drops by the following falling edge. The load strobe is sampled at P+1, the advances at P+2 through P+57, and done_o, the assembled word and valid_o are visible from P+58. The bench moves start only on falling edges and reads every output at a falling edge. It counts falling edges from P until done_o first appears and requires that count to be exactly 58. A bench model of the port counts the strobe edges it sees, so the single load, the 56 advances and the ignored mid-run start are all checked against the port's view of the readout.

// File: rtl/serial_id_pkg.sv
package serial_id_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_LOAD  = 2'd1,
    RD_SHIFT = 2'd2,
    RD_DONE  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/serial_id_seq.sv
module serial_id_seq
  import serial_id_pkg::*;
#(
  parameter int ID_W  = 57,
  localparam int CNT_W = $clog2(ID_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic load_req_o,
  output logic shift_req_o,
  output logic sample_o,
  output logic finish_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ID_W - 1);

  rd_state_e        state_q;
  logic [CNT_W-1:0] left_q;

  // start counts only when no readout is running
  assign accept_o    = start_i && (state_q == RD_IDLE || state_q == RD_DONE);
  assign load_req_o  = (state_q == RD_LOAD);
  // no advance is requested for the final sample
  assign shift_req_o = (state_q == RD_SHIFT) && (left_q != '0);
  assign sample_o    = (state_q == RD_SHIFT);
  assign finish_o    = (state_q == RD_SHIFT) && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      left_q  <= '0;
    end else begin
      case (state_q)
        RD_IDLE, RD_DONE: if (start_i) state_q <= RD_LOAD;
        RD_LOAD: begin
          state_q <= RD_SHIFT;
          left_q  <= LAST;
        end
        RD_SHIFT: begin
          if (left_q == '0) state_q <= RD_DONE;
          else              left_q  <= left_q - 1'b1;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_id_retime.sv
module serial_id_retime #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  // falling-edge launch keeps every strobe change inside the low phase
  for (genvar i = 0; i < N; i++) begin : g_lane
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= d_i[i];
    end
  end
endmodule

// File: rtl/serial_id_collect.sv
module serial_id_collect #(
  parameter int                ID_W  = 57,
  parameter int                PFX_W = 2,
  parameter logic [PFX_W-1:0]  PFX   = 2'b10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  input  logic            sample_i,
  input  logic            finish_i,
  input  logic            sdo_i,
  output logic [ID_W-1:0] value_o,
  output logic            done_o,
  output logic            valid_o
);
  logic [ID_W-1:0] acc_q;
  logic [ID_W-1:0] acc_next;

  // MSB arrives first, so each new bit enters at the bottom
  assign acc_next = {acc_q[ID_W-2:0], sdo_i};
  assign value_o  = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      done_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (sample_i) acc_q <= acc_next;
      if (accept_i)      valid_o <= 1'b0;
      else if (finish_i) valid_o <= (acc_next[ID_W-1 -: PFX_W] == PFX);
    end
  end
endmodule

// File: rtl/serial_id_reader.sv
module serial_id_reader #(
  parameter int               ID_W  = 57,
  parameter int               PFX_W = 2,
  parameter logic [PFX_W-1:0] PFX   = 2'b10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output logic            id_load_o,
  output logic            id_shift_o,
  output logic            id_feed_o,
  input  logic            id_sdo_i,
  output logic [ID_W-1:0] id_value_o,
  output logic            done_o,
  output logic            valid_o
);
  logic accept, load_req, shift_req, sample, finish;
  logic [1:0] strobe_q;

  serial_id_seq #(.ID_W(ID_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .accept_o(accept), .load_req_o(load_req), .shift_req_o(shift_req),
    .sample_o(sample), .finish_o(finish)
  );

  serial_id_retime #(.N(2)) u_retime (
    .clk(clk), .rst_n(rst_n),
    .d_i({shift_req, load_req}), .q_o(strobe_q)
  );

  serial_id_collect #(.ID_W(ID_W), .PFX_W(PFX_W), .PFX(PFX)) u_collect (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .sample_i(sample),
    .finish_i(finish), .sdo_i(id_sdo_i),
    .value_o(id_value_o), .done_o(done_o), .valid_o(valid_o)
  );

  assign id_load_o  = strobe_q[0];
  assign id_shift_o = strobe_q[1];
  assign id_feed_o  = 1'b0;
endmodule

// File: rtl/serial_id_reader_chk.sv
module serial_id_reader_chk #(
  parameter int               ID_W  = 57,
  parameter int               PFX_W = 2,
  parameter logic [PFX_W-1:0] PFX   = 2'b10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            id_load_o,
  input logic            id_shift_o,
  input logic [ID_W-1:0] id_value_o,
  input logic            done_o,
  input logic            valid_o
);
  localparam int SC_W = $clog2(ID_W) + 1;
  logic [SC_W-1:0] adv_cnt;

  // advances seen by the port since the last load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          adv_cnt <= '0;
    else if (id_load_o)  adv_cnt <= '0;
    else if (id_shift_o) adv_cnt <= adv_cnt + 1'b1;
  end

  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_load_o && id_shift_o));
  a_r3_adv_count: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> adv_cnt == SC_W'(ID_W - 1));
  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    id_load_o |=> !id_load_o);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_valid_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> id_value_o[ID_W-1 -: PFX_W] == PFX);
  a_r9_value_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o)) |-> $stable(id_value_o));

  // R4: strobes may only rise while the clock is low
  always @(posedge id_shift_o) begin
    if (rst_n) a_r4_shift_low_phase: assert (!clk);
  end
  always @(posedge id_load_o) begin
    if (rst_n) a_r4_load_low_phase: assert (!clk);
  end
endmodule

bind serial_id_reader serial_id_reader_chk #(.ID_W(ID_W), .PFX_W(PFX_W), .PFX(PFX)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_load_o(id_load_o), .id_shift_o(id_shift_o),
  .id_value_o(id_value_o), .done_o(done_o), .valid_o(valid_o)
);

// File: tb/serial_id_reader_bench.sv
module serial_id_reader_bench;
  localparam int W = 57;
  localparam int NV = 5;
  localparam logic [W-1:0] VEC_ID [NV] = '{
    {2'b10, 55'h2AAAAAAAAAAAAA},
    {2'b10, 55'h00000000000000},
    {2'b11, 55'h7FFFFFFFFFFFFF},
    {2'b01, 55'h12345678ABCDEF},
    {2'b00, 55'h55555555555555}
  };
  localparam bit VEC_OK [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic ld, sh, feed, sdo, done, valid;
  logic [W-1:0] value;
  logic [W-1:0] fuse_id = '0, port_sr = '0;
  int tests = 0, fails = 0;
  int n_load = 0, n_shift = 0, n_feed = 0, n_phase = 0;

  always #2 clk = ~clk;

  serial_id_reader u_serial_id_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .id_load_o(ld), .id_shift_o(sh), .id_feed_o(feed), .id_sdo_i(sdo),
    .id_value_o(value), .done_o(done), .valid_o(valid)
  );

  // identifier port model: load wins over advance, both low holds
  always @(posedge clk) begin
    if (ld)      port_sr <= fuse_id;
    else if (sh) port_sr <= {port_sr[W-2:0], feed};
  end
  assign sdo = port_sr[W-1];

  always @(posedge clk) if (rst_n) begin
    if (ld)   n_load++;
    if (sh)   n_shift++;
    if (feed) n_feed++;
  end
  always @(posedge sh or posedge ld) if (clk) n_phase++;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // one readout; optional stray start at cycle 'stray' (0 = none)
  task automatic readout(input logic [W-1:0] id, input bit ok, input int stray);
    int k = 0;
    fuse_id = id;
    n_load = 0; n_shift = 0; n_feed = 0;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    chk("R7 valid cleared at start", valid, 0);
    while (!done && k < 100) begin
      @(negedge clk); k++;
      start = (k == stray);
    end
    start = 1'b0;
    chk("R6 done latency", k, 58);
    chk("R5 value", value, id);
    chk("R7 valid", valid, ok);
    chk("R2 load count", n_load, 1);
    chk("R3 shift count", n_shift, 56);
    chk("R3 feed zero", n_feed, 0);
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
    repeat (6) @(negedge clk);
    chk("R9 value held", value, id);
    chk("R9 valid held", valid, ok);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset flags", {ld, sh, feed, done, valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {ld, sh, feed, done, valid}, 0);
    chk("R1 value zero", value, 0);
    for (int i = 0; i < NV; i++) readout(VEC_ID[i], VEC_OK[i], 0);
    // R8: stray start in the middle of a readout
    readout(VEC_ID[0], 1'b1, 20);
    chk("R8 no restart after stray start", n_load, 1);
    // R8: stray start on the last shift cycle
    readout(VEC_ID[3], 1'b0, 57);
    chk("R4 strobe phase", n_phase, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule